// File: doc/BRIEF.md
# Dual-Buffer Page Program and Erase Controller

This block is the device-side engine of a serial page-oriented flash model. A shared serial front end hands it whole bytes together with the chip-select level. The first byte of a frame is a command code and the next three bytes form a 24-bit address. For the two buffer-load commands, any bytes after the address land in one of two page-sized staging buffers. For the program and erase commands, nothing happens until chip select is released. At that moment the block starts a self-timed operation on a small register-modelled main array.

Two layouts are supported, selected by `bin_mode`. The standard layout has pages of `2^BIN_BITS + EXTRA_BYTES` bytes. The binary layout has pages of `2^BIN_BITS` bytes. The chosen layout sets where the page number and the byte offset sit in the address, and where writes into a buffer wrap. Each operation lasts a fixed number of clock cycles, taken from a parameter, and `rdy` plus bit 7 of `status` report busy for that whole time. An array read port lets the surrounding model read the stored bytes back at any time. `bin_mode` is expected to change only while the block is idle.

Top module: `dualbuf_prog_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `rdy` is 1, `status` equals 8'h80, and every byte of the array and of both buffers holds 8'hFF.
- R2: Code 8'h84 loads buffer 1 and code 8'h87 loads buffer 2. The bytes after the third address byte are stored one per `byte_vld`. The start offset is address bits [3:0] in standard mode, reduced by 10 when it is 10 or more. In binary mode the start offset is bits [2:0].
- R3: A buffer load that passes the last byte of the buffer (offset 9 in standard mode, offset 7 in binary mode) continues at offset 0. Loading continues until chip select rises.
- R4: Codes 8'h83 and 8'h86 set every byte of the addressed page to 8'hFF and then copy buffer 1 or buffer 2 into the page's active bytes. Busy lasts ERASE_CYC+PROG_CYC cycles.
- R5: Codes 8'h88 and 8'h89 AND buffer 1 or buffer 2 into the active bytes of the addressed page, with no erase. Busy lasts PROG_CYC cycles.
- R6: Code 8'h81 sets the addressed page to all 8'hFF, with busy lasting ERASE_CYC cycles. The page number is address bits [7:4] in standard mode. Higher address bits are ignored.
- R7: Code 8'h50 sets all eight pages whose page number matches the addressed one above its lowest 3 bits to 8'hFF. Busy lasts BLOCK_CYC cycles.
- R8: A program or erase starts only on the clock after chip select is first sampled high. `rdy` falls then, and `status[7]` is 0 for exactly the busy time. The array changes only in the cycle in which `rdy` returns to 1.
- R9: A buffer load whose code byte arrives while busy stores nothing. A program or erase whose chip-select rise happens while busy starts nothing.
- R10: A frame whose chip select rises before all three address bytes have arrived starts no operation and changes no state.
- R11: In binary mode the page number is address bits [6:3]. Program commands copy only buffer offsets 0 to 7, and the page's two extra bytes become 8'hFF under R4 and are left alone under R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bin_mode | input | 1 | 1 selects power-of-two pages, 0 selects standard pages |
| cs_n | input | 1 | Chip select from the front end, active low, synchronous to clk |
| byte_vld | input | 1 | A received byte is on byte_data this cycle |
| byte_data | input | 8 | Received byte |
| rd_page | input | PG_BITS | Array read page |
| rd_off | input | BIN_BITS+1 | Array read byte offset |
| rd_data | output | 8 | Array byte at rd_page/rd_off (8'hFF beyond the page) |
| rdy | output | 1 | 1 when idle, 0 while an operation runs |
| status | output | 8 | Status byte; bit 7 is the ready flag, other bits 0 |

## Verification
The bench targets several corner cases. One is a buffer load that starts near the end of the buffer, including a standard-mode start offset of 10 or more. A design that wraps at the wrong place corrupts or drops bytes, and this shows up after a later program. Programs without erase are issued onto pages that already hold data. A design that overwrites instead of ANDing leaves bits that went back to 1. Block erases use page addresses whose low three bits are not zero, to catch a design that clears the wrong eight pages. Commands are sent while busy, and frames are cut short inside the address. A design that honoured either would show a wrong busy time or changed array bytes. Binary-mode programs check that the two extra bytes of each page are neither copied nor preserved by mistake.

// File: rtl/dbp_pkg.sv
// Shared command codes and the decoded internal action type.
// Assumes single-byte command codes and a three-byte address field.
package dbp_pkg;

    localparam logic [7:0] OP_WR_B1     = 8'h84;
    localparam logic [7:0] OP_WR_B2     = 8'h87;
    localparam logic [7:0] OP_PGM_E_B1  = 8'h83;
    localparam logic [7:0] OP_PGM_E_B2  = 8'h86;
    localparam logic [7:0] OP_PGM_B1    = 8'h88;
    localparam logic [7:0] OP_PGM_B2    = 8'h89;
    localparam logic [7:0] OP_ERASE_PG  = 8'h81;
    localparam logic [7:0] OP_ERASE_BLK = 8'h50;

    localparam int BLK_SHIFT = 3;   // pages per block = 2**BLK_SHIFT

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_ERASE_PG,
        ACT_ERASE_BLK,
        ACT_PGM,
        ACT_PGM_ERASE
    } act_t;

    function automatic logic is_buf_wr(input logic [7:0] op);
        return (op == OP_WR_B1) || (op == OP_WR_B2);
    endfunction

    function automatic logic uses_buf2(input logic [7:0] op);
        return (op == OP_PGM_E_B2) || (op == OP_PGM_B2);
    endfunction

    function automatic act_t decode_act(input logic [7:0] op);
        case (op)
            OP_ERASE_PG:               return ACT_ERASE_PG;
            OP_ERASE_BLK:              return ACT_ERASE_BLK;
            OP_PGM_B1, OP_PGM_B2:      return ACT_PGM;
            OP_PGM_E_B1, OP_PGM_E_B2:  return ACT_PGM_ERASE;
            default:                   return ACT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dbp_cmd_rx.sv
// Frame decoder: counts bytes inside a chip-select window, captures the
// command code and address, steers load bytes into a buffer with wrap, and
// issues a start request on the chip-select rising edge.
// Assumes cs_n and byte_vld are already synchronous to clk.
module dbp_cmd_rx
    import dbp_pkg::*;
#(
    parameter int BIN_BITS = 3,
    parameter int STD_SZ   = 10,
    parameter int PG_BITS  = 4,
    localparam int OFF_W   = BIN_BITS + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bin_mode,
    input  logic               cs_n,
    input  logic               byte_vld,
    input  logic [7:0]         byte_data,
    input  logic               busy,
    output logic               wr_en,
    output logic               wr_sel,
    output logic [OFF_W-1:0]   wr_off,
    output logic [7:0]         wr_data,
    output logic               start,
    output act_t               start_act,
    output logic               start_sel,
    output logic [PG_BITS-1:0] start_page
);

    localparam int               BIN_SZ   = 1 << BIN_BITS;
    localparam logic [OFF_W-1:0] STD_L    = OFF_W'(STD_SZ);
    localparam logic [OFF_W-1:0] STD_LAST = OFF_W'(STD_SZ - 1);
    localparam logic [OFF_W-1:0] BIN_LAST = OFF_W'(BIN_SZ - 1);
    localparam logic [2:0]       HDR_DONE = 3'd4;

    logic             cs_q;
    logic [2:0]       nbytes;
    logic [7:0]       op;
    logic [23:0]      addr;
    logic             open_ok;
    logic [OFF_W-1:0] ptr;
    logic [23:0]      addr_next;
    logic [OFF_W-1:0] off_raw;
    logic [OFF_W-1:0] off_first;
    logic [OFF_W-1:0] last_idx;

    // Address as it will look once the current byte is shifted in.
    always_comb begin
        addr_next = {addr[15:0], byte_data};
        off_raw   = addr_next[OFF_W-1:0];
        if (bin_mode)
            off_first = {1'b0, addr_next[BIN_BITS-1:0]};
        else if (off_raw >= STD_L)
            off_first = off_raw - STD_L;
        else
            off_first = off_raw;
        last_idx = bin_mode ? BIN_LAST : STD_LAST;
    end

    // Buffer write strobe and start request towards the sequencer.
    always_comb begin
        wr_en      = !cs_n && byte_vld && (nbytes == HDR_DONE) && open_ok && is_buf_wr(op);
        wr_sel     = (op == OP_WR_B2);
        wr_off     = ptr;
        wr_data    = byte_data;
        start_act  = decode_act(op);
        start_sel  = uses_buf2(op);
        start_page = bin_mode ? addr[BIN_BITS +: PG_BITS] : addr[OFF_W +: PG_BITS];
        start      = cs_n && !cs_q && (nbytes == HDR_DONE) && !busy && (start_act != ACT_NONE);
    end

    // Previous chip-select level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b1;
        else        cs_q <= cs_n;
    end

    // Byte counter, header capture and buffer pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nbytes  <= '0;
            op      <= '0;
            addr    <= '0;
            open_ok <= 1'b0;
            ptr     <= '0;
        end else if (cs_n) begin
            nbytes <= '0;
        end else if (byte_vld) begin
            case (nbytes)
                3'd0: begin
                    op      <= byte_data;
                    open_ok <= !busy;
                    nbytes  <= 3'd1;
                end
                3'd1, 3'd2: begin
                    addr   <= addr_next;
                    nbytes <= nbytes + 3'd1;
                end
                3'd3: begin
                    addr   <= addr_next;
                    ptr    <= off_first;
                    nbytes <= HDR_DONE;
                end
                default: begin
                    if (wr_en) ptr <= (ptr == last_idx) ? '0 : ptr + 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/dbp_op_seq.sv
// Self-timed operation sequencer: latches an accepted action, holds busy
// for a parameter-defined number of cycles, and pulses fire in the last one.
// Assumes every duration parameter is at least 1 and fits in CNT_W bits.
module dbp_op_seq
    import dbp_pkg::*;
#(
    parameter int ERASE_CYC = 5,
    parameter int BLOCK_CYC = 7,
    parameter int PROG_CYC  = 3,
    parameter int CNT_W     = 16,
    parameter int PG_BITS   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  act_t               start_act,
    input  logic               start_sel,
    input  logic [PG_BITS-1:0] start_page,
    output logic               busy,
    output logic               fire,
    output act_t               f_act,
    output logic               f_sel,
    output logic [PG_BITS-1:0] f_page
);

    logic [CNT_W-1:0] remain;

    function automatic logic [CNT_W-1:0] last_tick(input act_t a);
        case (a)
            ACT_ERASE_PG:  return CNT_W'(ERASE_CYC - 1);
            ACT_ERASE_BLK: return CNT_W'(BLOCK_CYC - 1);
            ACT_PGM:       return CNT_W'(PROG_CYC - 1);
            ACT_PGM_ERASE: return CNT_W'(ERASE_CYC + PROG_CYC - 1);
            default:       return '0;
        endcase
    endfunction

    // Final cycle of the running operation.
    always_comb fire = busy && (remain == '0);

    // Busy timer and latched operation descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
            f_act  <= ACT_NONE;
            f_sel  <= 1'b0;
            f_page <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= last_tick(start_act);
            f_act  <= start_act;
            f_sel  <= start_sel;
            f_page <= start_page;
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end

endmodule

// File: rtl/dbp_store.sv
// Storage: two staging buffers and the main array as registers. Applies a
// finished erase or program in one cycle and offers a combinational read.
// Assumes wr_en and fire are never both targeting the same buffer byte.
module dbp_store
    import dbp_pkg::*;
#(
    parameter int BIN_BITS = 3,
    parameter int STD_SZ   = 10,
    parameter int PG_BITS  = 4,
    localparam int OFF_W   = BIN_BITS + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bin_mode,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [OFF_W-1:0]   wr_off,
    input  logic [7:0]         wr_data,
    input  logic               fire,
    input  act_t               f_act,
    input  logic               f_sel,
    input  logic [PG_BITS-1:0] f_page,
    input  logic [PG_BITS-1:0] rd_page,
    input  logic [OFF_W-1:0]   rd_off,
    output logic [7:0]         rd_data
);

    localparam int PAGES  = 1 << PG_BITS;
    localparam int BIN_SZ = 1 << BIN_BITS;

    logic [7:0] pbuf [2][STD_SZ];
    logic [7:0] mem  [PAGES][STD_SZ];

    // Array read port, bytes beyond the page read as erased.
    always_comb rd_data = (int'(rd_off) < STD_SZ) ? mem[rd_page][rd_off] : 8'hFF;

    // Buffer loads and completion of erase/program operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 2; s++)
                for (int b = 0; b < STD_SZ; b++) pbuf[s][b] <= 8'hFF;
            for (int p = 0; p < PAGES; p++)
                for (int b = 0; b < STD_SZ; b++) mem[p][b] <= 8'hFF;
        end else begin
            if (wr_en) pbuf[wr_sel][wr_off] <= wr_data;
            if (fire) begin
                for (int p = 0; p < PAGES; p++) begin
                    for (int b = 0; b < STD_SZ; b++) begin
                        case (f_act)
                            ACT_ERASE_PG:
                                if (PG_BITS'(p) == f_page) mem[p][b] <= 8'hFF;
                            ACT_ERASE_BLK:
                                if ((p >> BLK_SHIFT) == (int'(f_page) >> BLK_SHIFT))
                                    mem[p][b] <= 8'hFF;
                            ACT_PGM_ERASE:
                                if (PG_BITS'(p) == f_page)
                                    mem[p][b] <= (b < (bin_mode ? BIN_SZ : STD_SZ))
                                                 ? pbuf[f_sel][b] : 8'hFF;
                            ACT_PGM:
                                if ((PG_BITS'(p) == f_page) && (b < (bin_mode ? BIN_SZ : STD_SZ)))
                                    mem[p][b] <= mem[p][b] & pbuf[f_sel][b];
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

endmodule

// File: rtl/dualbuf_prog_ctrl.sv
// Top level: dual-buffer load, page/block erase and buffer-to-page program
// engine with a ready flag and status byte.
// Assumes a front end that delivers whole bytes and a synchronous cs_n.
module dualbuf_prog_ctrl
    import dbp_pkg::*;
#(
    parameter int BIN_BITS    = 3,
    parameter int EXTRA_BYTES = 2,
    parameter int PG_BITS     = 4,
    parameter int ERASE_CYC   = 5,
    parameter int BLOCK_CYC   = 7,
    parameter int PROG_CYC    = 3,
    parameter int CNT_W       = 16,
    localparam int OFF_W      = BIN_BITS + 1,
    localparam int STD_SZ     = (1 << BIN_BITS) + EXTRA_BYTES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bin_mode,
    input  logic               cs_n,
    input  logic               byte_vld,
    input  logic [7:0]         byte_data,
    input  logic [PG_BITS-1:0] rd_page,
    input  logic [OFF_W-1:0]   rd_off,
    output logic [7:0]         rd_data,
    output logic               rdy,
    output logic [7:0]         status
);

    logic               busy;
    logic               wr_en;
    logic               wr_sel;
    logic [OFF_W-1:0]   wr_off;
    logic [7:0]         wr_data;
    logic               start;
    act_t               start_act;
    logic               start_sel;
    logic [PG_BITS-1:0] start_page;
    logic               fire;
    act_t               f_act;
    logic               f_sel;
    logic [PG_BITS-1:0] f_page;

    dbp_cmd_rx #(.BIN_BITS(BIN_BITS), .STD_SZ(STD_SZ), .PG_BITS(PG_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n), .bin_mode(bin_mode), .cs_n(cs_n),
        .byte_vld(byte_vld), .byte_data(byte_data), .busy(busy),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_off(wr_off), .wr_data(wr_data),
        .start(start), .start_act(start_act), .start_sel(start_sel),
        .start_page(start_page)
    );

    dbp_op_seq #(.ERASE_CYC(ERASE_CYC), .BLOCK_CYC(BLOCK_CYC), .PROG_CYC(PROG_CYC),
                 .CNT_W(CNT_W), .PG_BITS(PG_BITS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_act(start_act),
        .start_sel(start_sel), .start_page(start_page), .busy(busy),
        .fire(fire), .f_act(f_act), .f_sel(f_sel), .f_page(f_page)
    );

    dbp_store #(.BIN_BITS(BIN_BITS), .STD_SZ(STD_SZ), .PG_BITS(PG_BITS)) u_store (
        .clk(clk), .rst_n(rst_n), .bin_mode(bin_mode),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_off(wr_off), .wr_data(wr_data),
        .fire(fire), .f_act(f_act), .f_sel(f_sel), .f_page(f_page),
        .rd_page(rd_page), .rd_off(rd_off), .rd_data(rd_data)
    );

    // Ready flag and status byte.
    always_comb begin
        rdy    = !busy;
        status = {!busy, 7'b0};
    end

endmodule

// File: rtl/dbp_chk.sv
// Assertion checker for dualbuf_prog_ctrl, attached by bind below.
// Assumes the port names of the top module.
module dbp_chk #(
    parameter int ERASE_CYC = 5,
    parameter int BLOCK_CYC = 7,
    parameter int PROG_CYC  = 3,
    parameter int PG_BITS   = 4,
    parameter int OFF_W     = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_n,
    input logic               rdy,
    input logic [PG_BITS-1:0] rd_page,
    input logic [OFF_W-1:0]   rd_off,
    input logic [7:0]         rd_data
);

    logic [15:0] busy_len;

    // Length of the current busy stretch in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)   busy_len <= '0;
        else if (rdy) busy_len <= '0;
        else          busy_len <= busy_len + 16'd1;
    end

    // R8
    start_on_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> ($past(cs_n) && !$past(cs_n, 2)));

    // R8
    no_start_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> !$fell(rdy));

    // R4 R5 R6 R7
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> ((busy_len == 16'(ERASE_CYC)) || (busy_len == 16'(BLOCK_CYC)) ||
                        (busy_len == 16'(PROG_CYC))  || (busy_len == 16'(ERASE_CYC + PROG_CYC))));

    // R8
    array_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(rd_page) && $stable(rd_off) && !$rose(rdy)) |-> $stable(rd_data));

endmodule

bind dualbuf_prog_ctrl dbp_chk #(
    .ERASE_CYC(ERASE_CYC), .BLOCK_CYC(BLOCK_CYC), .PROG_CYC(PROG_CYC),
    .PG_BITS(PG_BITS), .OFF_W(OFF_W)
) u_dbp_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rdy(rdy),
    .rd_page(rd_page), .rd_off(rd_off), .rd_data(rd_data)
);

// File: tb/dualbuf_prog_ctrl_test.sv
module dualbuf_prog_ctrl_test;

    localparam int CLK_P = 10;
    localparam int E_C   = 5;
    localparam int B_C   = 7;
    localparam int P_C   = 3;
    localparam int NPG   = 16;
    localparam int STD   = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bin_mode = 1'b0;
    logic       cs_n = 1'b1;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic [3:0] rd_page = '0;
    logic [3:0] rd_off = '0;
    logic [7:0] rd_data;
    logic       rdy;
    logic [7:0] status;

    dualbuf_prog_ctrl #(.ERASE_CYC(E_C), .BLOCK_CYC(B_C), .PROG_CYC(P_C)) uut (
        .clk(clk), .rst_n(rst_n), .bin_mode(bin_mode), .cs_n(cs_n),
        .byte_vld(byte_vld), .byte_data(byte_data), .rd_page(rd_page),
        .rd_off(rd_off), .rd_data(rd_data), .rdy(rdy), .status(status)
    );

    always #(CLK_P/2) clk = ~clk;

    logic [7:0] rmem [NPG][STD];
    logic [7:0] rbuf [2][STD];
    logic [7:0] tx [32];
    int total = 0;
    int bad = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int ref_size();
        return bin_mode ? 8 : STD;
    endfunction

    function automatic int ref_page(input logic [23:0] a);
        return bin_mode ? int'(a[6:3]) : int'(a[7:4]);
    endfunction

    function automatic int ref_off(input logic [23:0] a);
        int o;
        if (bin_mode) return int'(a[2:0]);
        o = int'(a[3:0]);
        return (o >= STD) ? o - STD : o;
    endfunction

    function automatic int exp_dur(input logic [7:0] op);
        case (op)
            8'h81: return E_C;
            8'h50: return B_C;
            8'h83, 8'h86: return E_C + P_C;
            8'h88, 8'h89: return P_C;
            default: return 0;
        endcase
    endfunction

    task automatic ref_write(input int s, input logic [23:0] a, input int n);
        int idx = ref_off(a);
        for (int i = 0; i < n; i++) begin
            rbuf[s][idx] = tx[i];
            idx = (idx == ref_size() - 1) ? 0 : idx + 1;
        end
    endtask

    task automatic ref_pe(input logic [7:0] op, input logic [23:0] a);
        int pg = ref_page(a);
        int sz = ref_size();
        int s = (op == 8'h86 || op == 8'h89) ? 1 : 0;
        case (op)
            8'h81: for (int b = 0; b < STD; b++) rmem[pg][b] = 8'hFF;
            8'h50: for (int p = 0; p < NPG; p++)
                       if ((p >> 3) == (pg >> 3))
                           for (int b = 0; b < STD; b++) rmem[p][b] = 8'hFF;
            8'h83, 8'h86: for (int b = 0; b < STD; b++)
                              rmem[pg][b] = (b < sz) ? rbuf[s][b] : 8'hFF;
            8'h88, 8'h89: for (int b = 0; b < sz; b++)
                              rmem[pg][b] = rmem[pg][b] & rbuf[s][b];
            default: ;
        endcase
    endtask

    task automatic send(input logic [7:0] op, input logic [23:0] a,
                        input int naddr, input int ndata);
        @(negedge clk);
        cs_n = 1'b0; byte_vld = 1'b1; byte_data = op;
        for (int i = 0; i < naddr; i++) begin
            @(negedge clk);
            byte_data = a[23 - 8*i -: 8];
        end
        for (int i = 0; i < ndata; i++) begin
            @(negedge clk);
            byte_data = tx[i];
        end
        @(negedge clk);
        byte_vld = 1'b0; cs_n = 1'b1;
    endtask

    task automatic wait_done(input int exp, input string tag);
        int n = 0;
        forever begin
            @(negedge clk);
            if (rdy) break;
            n++;
            if (n == 1) check(status == 8'h00, tag, "status while busy", status, 8'h00);
            if (n > 60) break;
        end
        check(n == exp, tag, "busy cycles", n, exp);
        check(status == 8'h80, tag, "status when idle", status, 8'h80);
    endtask

    task automatic compare_mem(input string tag);
        int mism = 0;
        int fa = 0, fe = 0;
        for (int p = 0; p < NPG; p++)
            for (int b = 0; b < STD; b++) begin
                rd_page = 4'(p); rd_off = 4'(b);
                #1;
                if (rd_data !== rmem[p][b]) begin
                    if (mism == 0) begin fa = int'(rd_data); fe = int'(rmem[p][b]); end
                    mism++;
                end
            end
        check(mism == 0, tag, "array contents", fa, fe);
    endtask

    task automatic do_cmd(input logic [7:0] op, input logic [23:0] a,
                          input int naddr, input int ndata, input string tag);
        if (naddr == 3) begin
            if (op == 8'h84) ref_write(0, a, ndata);
            if (op == 8'h87) ref_write(1, a, ndata);
            ref_pe(op, a);
        end
        send(op, a, naddr, ndata);
        wait_done((naddr == 3) ? exp_dur(op) : 0, tag);
        compare_mem(tag);
    endtask

    task automatic fill_tx(input int base);
        for (int i = 0; i < 32; i++) tx[i] = 8'(base + 37 * i + i * i);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int p = 0; p < NPG; p++) for (int b = 0; b < STD; b++) rmem[p][b] = 8'hFF;
        for (int s = 0; s < 2; s++) for (int b = 0; b < STD; b++) rbuf[s][b] = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state, buffers checked by an AND-program of buffer 1
        @(negedge clk);
        check(rdy == 1'b1, "R1", "rdy after reset", rdy, 1);
        check(status == 8'h80, "R1", "status after reset", status, 8'h80);
        compare_mem("R1");
        do_cmd(8'h88, 24'h000050, 3, 0, "R1");

        // R2 R3 standard-mode wrap from offset 7, page 2, high junk bits
        fill_tx(3);
        do_cmd(8'h84, 24'hA50007, 3, 6, "R3");
        do_cmd(8'h83, 24'h800025, 3, 0, "R4");
        // R2 start offset 12 folds to 2, buffer 2
        fill_tx(90);
        do_cmd(8'h87, 24'h00000C, 3, 4, "R2");
        do_cmd(8'h86, 24'h000030, 3, 0, "R4");
        // R5 AND into page 2 which already holds data
        fill_tx(200);
        do_cmd(8'h87, 24'h000000, 3, 10, "R5");
        do_cmd(8'h89, 24'h000020, 3, 0, "R5");
        // R6 page erase of page 3
        do_cmd(8'h81, 24'hFF003F, 3, 0, "R6");
        // R7 fill upper pages, then block erase with low page bits 101
        for (int p = 8; p < 16; p++) do_cmd(8'h83, 24'(p << 4), 3, 0, "R7");
        do_cmd(8'h50, 24'h0000D3, 3, 0, "R7");

        // R9 buffer load while busy is dropped
        fill_tx(55);
        do_cmd(8'h84, 24'h000000, 3, 10, "R9");
        ref_pe(8'h83, 24'h000040);
        send(8'h83, 24'h000040, 3, 0);
        fill_tx(1);
        send(8'h84, 24'h000000, 3, 1);
        while (!rdy) @(negedge clk);
        compare_mem("R9");
        do_cmd(8'h83, 24'h000050, 3, 0, "R9");
        // R9 erase whose chip-select rise falls inside busy is dropped
        ref_pe(8'h50, 24'h000000);
        send(8'h50, 24'h000000, 3, 0);
        send(8'h81, 24'h000040, 3, 0);
        while (!rdy) @(negedge clk);
        repeat (2) @(negedge clk);
        check(rdy == 1'b1, "R9", "no late start", rdy, 1);
        compare_mem("R9");

        // R10 truncated frames
        do_cmd(8'h81, 24'h000050, 2, 0, "R10");
        do_cmd(8'h83, 24'h000060, 1, 0, "R10");
        do_cmd(8'h50, 24'h000000, 0, 0, "R10");

        // R11 binary mode: wrap at 8, page at bits [6:3]
        @(negedge clk) bin_mode = 1'b1;
        fill_tx(17);
        do_cmd(8'h84, 24'h000005, 3, 6, "R11");
        do_cmd(8'h83, 24'h000038, 3, 0, "R11");
        do_cmd(8'h88, 24'h000050, 3, 0, "R11");
        do_cmd(8'h50, 24'h000049, 3, 0, "R11");

        // Random mix
        for (int it = 0; it < 90; it++) begin
            int r = int'($urandom % 8);
            logic [23:0] a = 24'($urandom);
            case (r)
                0, 1: begin
                    fill_tx(int'($urandom % 256));
                    do_cmd((r == 0) ? 8'h84 : 8'h87, a, 3, int'($urandom % 15), "R2");
                end
                2: do_cmd(($urandom % 2) ? 8'h86 : 8'h83, a, 3, 0, "R4");
                3: do_cmd(($urandom % 2) ? 8'h89 : 8'h88, a, 3, 0, "R5");
                4: do_cmd(8'h81, a, 3, 0, "R6");
                5: do_cmd(8'h50, a, 3, 0, "R7");
                6: do_cmd(($urandom % 2) ? 8'h83 : 8'h81, a, int'($urandom % 3), 0, "R10");
                default: begin
                    @(negedge clk) bin_mode = ~bin_mode;
                end
            endcase
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule